// File: doc/BRIEF.md
# Read-Only NAND Flash Target Model

This block models the target side of a pair of small-page NAND flash devices that can only be read. A host drives an 8-bit bus together with command-latch and address-latch qualifiers, an active-low write strobe, an active-low read strobe and one active-low enable per device. Command bytes choose a read mode. Three address bytes then place a linear byte pointer into memory organised as 528-byte pages, with 32 pages per erase block. Each read strobe returns the byte at the pointer and moves the pointer on by one.

All inputs are sampled on the block clock, and a strobe acts on its falling edge as seen by that clock. The read mode picks the start area within a page: offset 0, 0x100 or 0x200. The second address byte is weighted as a high page byte and the third as a low page byte. Each device keeps its own mode, address-cycle counter, pointer, error flag and ready line. The devices never report busy. The stored contents are not loaded from outside. A parameter selects either the erased state, where every byte is 0xFF, or a computed address pattern that makes pointer arithmetic visible at the pins.

Top module: `nandrd_target`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `bus_oe` is 0, `bus_out` is 0x00, `rdy` is 2'b00 and `cmd_err` is 2'b00.
- R2: A low `ce0_n` selects device 0, and it takes priority when both enables are low. A low `ce1_n` with `ce0_n` high selects device 1. When both enables are high, strobes change no device state and no output.
- R3: A write-strobe falling edge with `cle` high is a command. Code 0x00 selects start offset 0, 0x01 selects offset 0x100 and 0x50 selects offset 0x200. Each of these read commands also sets the address-cycle count to 0. Code 0xFF returns the mode to idle, which uses offset 0, and clears that device's error flag.
- R4: The first address byte, taken on a write-strobe falling edge with `ale` high and `cle` low, sets the pointer to the byte value plus the offset of the current mode.
- R5: The second address byte adds byte×135168 (528×256) to the pointer. The third adds byte×528. Any further address bytes are ignored until the next read command.
- R6: Pointer arithmetic wraps modulo 2^ADDR_W.
- R7: A read-strobe falling edge with `cle` and `ale` low drives the selected device's byte at the pointer onto `bus_out` with `bus_oe` = 1 on the next clock, then increments that device's pointer.
- R8: With FILL_PATTERN = 0 every byte reads 0xFF. With FILL_PATTERN = 1 the byte at pointer p is the XOR of the four bytes of p (zero-extended to 32 bits), XORed with 0x00 for device 0 or 0xA5 for device 1.
- R9: A clock with the device selected and both strobes high clears `bus_oe` on the next clock and sets that device's `rdy` bit. A `rdy` bit never falls outside reset.
- R10: Any other command code sets that device's sticky `cmd_err` bit and leaves the mode unchanged.
- R11: The two devices keep separate pointers, modes and error flags. Activity on one device does not alter the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ce0_n | input | 1 | Device 0 enable, active low |
| ce1_n | input | 1 | Device 1 enable, active low |
| cle | input | 1 | Command-latch qualifier |
| ale | input | 1 | Address-latch qualifier |
| we_n | input | 1 | Write strobe, active low |
| re_n | input | 1 | Read strobe, active low |
| bus_in | input | 8 | Command or address byte from host |
| bus_out | output | 8 | Read data byte |
| bus_oe | output | 1 | High while the block drives the data byte |
| rdy | output | 2 | Ready line per device |
| cmd_err | output | 2 | Sticky unknown-command flag per device |

## Verification
The checker watches, on every clock, the properties that involve only port activity. These are the reset state, a ready line that never falls, release of the output enable after an idle cycle, and output enable rising only after a qualified read strobe. It also checks that an error flag rises only after a command strobe to that device, and that error flags stay unchanged while no device is selected. Only the directed scenarios can show the pointer arithmetic. This covers the mode offsets, the 528 and 135168 weights, wrap-around, ignored extra address bytes, the independence of the two devices and the erased fill value, because each of these appears only as the value of a returned byte.

// File: rtl/nandrd_pkg.sv
package nandrd_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_A    = 2'd1,
    MODE_B    = 2'd2,
    MODE_C    = 2'd3
  } rd_mode_e;

  localparam logic [7:0] CMD_RESET  = 8'hFF;
  localparam logic [7:0] CMD_READ_A = 8'h00;
  localparam logic [7:0] CMD_READ_B = 8'h01;
  localparam logic [7:0] CMD_READ_C = 8'h50;

  localparam int unsigned PAGE_BYTES = 528;
  localparam int unsigned HI_WEIGHT  = PAGE_BYTES * 256;

  function automatic logic [9:0] mode_offset(rd_mode_e m);
    case (m)
      MODE_B:  return 10'h100;
      MODE_C:  return 10'h200;
      default: return 10'h000;
    endcase
  endfunction

  function automatic logic [7:0] fold_byte(logic [31:0] a, logic [7:0] key);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ key;
  endfunction

endpackage

// File: rtl/nandrd_strobe.sv
module nandrd_strobe (
  input  logic clk,
  input  logic rst,
  input  logic ce0_n,
  input  logic ce1_n,
  input  logic cle,
  input  logic ale,
  input  logic we_n,
  input  logic re_n,
  output logic sel_valid,
  output logic sel_idx,
  output logic cmd_stb,
  output logic addr_stb,
  output logic rd_stb,
  output logic idle
);
  logic we_q, re_q;
  logic we_fall, re_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q <= 1'b1;
      re_q <= 1'b1;
    end else begin
      we_q <= we_n;
      re_q <= re_n;
    end
  end

  assign we_fall   = we_q & ~we_n;
  assign re_fall   = re_q & ~re_n;
  assign sel_valid = ~ce0_n | ~ce1_n;
  assign sel_idx   = ce0_n;
  assign cmd_stb   = sel_valid & we_fall & cle;
  assign addr_stb  = sel_valid & we_fall & ~cle & ale;
  assign rd_stb    = sel_valid & re_fall & ~cle & ~ale;
  assign idle      = sel_valid & we_n & re_n;
endmodule

// File: rtl/nandrd_die.sv
module nandrd_die
  import nandrd_pkg::*;
#(
  parameter int unsigned ADDR_W       = 24,
  parameter logic [7:0]  DEV_KEY      = 8'h00,
  parameter bit          FILL_PATTERN = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sel,
  input  logic       cmd_stb,
  input  logic       addr_stb,
  input  logic       rd_stb,
  input  logic       idle,
  input  logic [7:0] din,
  output logic [7:0] rd_byte,
  output logic       err,
  output logic       rdy
);
  localparam int unsigned CNT_MAX = 3;

  rd_mode_e          mode;
  logic [1:0]        acnt;
  logic [ADDR_W-1:0] ptr;
  logic [63:0]       nxt_wide;

  always_comb begin
    case (acnt)
      2'd0:    nxt_wide = 64'(din) + 64'(mode_offset(mode));
      2'd1:    nxt_wide = 64'(ptr) + 64'(din) * 64'(HI_WEIGHT);
      default: nxt_wide = 64'(ptr) + 64'(din) * 64'(PAGE_BYTES);
    endcase
  end

  generate
    if (FILL_PATTERN) begin : g_pattern
      assign rd_byte = fold_byte(32'(ptr), DEV_KEY);
    end else begin : g_erased
      assign rd_byte = 8'hFF;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= MODE_IDLE;
      acnt <= 2'd0;
      ptr  <= '0;
      err  <= 1'b0;
      rdy  <= 1'b0;
    end else if (sel) begin
      if (idle) rdy <= 1'b1;
      if (cmd_stb) begin
        case (din)
          CMD_RESET: begin
            mode <= MODE_IDLE;
            err  <= 1'b0;
          end
          CMD_READ_A: begin
            mode <= MODE_A;
            acnt <= 2'd0;
          end
          CMD_READ_B: begin
            mode <= MODE_B;
            acnt <= 2'd0;
          end
          CMD_READ_C: begin
            mode <= MODE_C;
            acnt <= 2'd0;
          end
          default: err <= 1'b1;
        endcase
      end else if (addr_stb) begin
        if (32'(acnt) < CNT_MAX) begin
          ptr  <= nxt_wide[ADDR_W-1:0];
          acnt <= acnt + 2'd1;
        end
      end else if (rd_stb) begin
        ptr <= ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nandrd_target.sv
module nandrd_target #(
  parameter int unsigned ADDR_W       = 24,
  parameter bit          FILL_PATTERN = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ce0_n,
  input  logic       ce1_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  input  logic       re_n,
  input  logic [7:0] bus_in,
  output logic [7:0] bus_out,
  output logic       bus_oe,
  output logic [1:0] rdy,
  output logic [1:0] cmd_err
);
  localparam int unsigned N_DEV = 2;

  logic sel_valid, sel_idx, cmd_stb, addr_stb, rd_stb, idle;
  logic [7:0] rd_byte [N_DEV];

  nandrd_strobe u_strobe (
    .clk(clk), .rst(rst), .ce0_n(ce0_n), .ce1_n(ce1_n),
    .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
    .sel_valid(sel_valid), .sel_idx(sel_idx), .cmd_stb(cmd_stb),
    .addr_stb(addr_stb), .rd_stb(rd_stb), .idle(idle)
  );

  generate
    for (genvar i = 0; i < N_DEV; i++) begin : g_dev
      nandrd_die #(
        .ADDR_W(ADDR_W),
        .DEV_KEY((i == 0) ? 8'h00 : 8'hA5),
        .FILL_PATTERN(FILL_PATTERN)
      ) u_die (
        .clk(clk), .rst(rst),
        .sel(sel_valid && (32'(sel_idx) == i)),
        .cmd_stb(cmd_stb), .addr_stb(addr_stb), .rd_stb(rd_stb),
        .idle(idle), .din(bus_in),
        .rd_byte(rd_byte[i]), .err(cmd_err[i]), .rdy(rdy[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_out <= 8'h00;
      bus_oe  <= 1'b0;
    end else if (rd_stb) begin
      bus_out <= rd_byte[sel_idx];
      bus_oe  <= 1'b1;
    end else if (idle) begin
      bus_oe  <= 1'b0;
    end
  end
endmodule

// File: rtl/nandrd_target_chk.sv
module nandrd_target_chk (
  input logic       clk,
  input logic       rst,
  input logic       ce0_n,
  input logic       ce1_n,
  input logic       cle,
  input logic       ale,
  input logic       we_n,
  input logic       re_n,
  input logic       bus_oe,
  input logic [1:0] rdy,
  input logic [1:0] cmd_err
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!bus_oe && rdy == 2'b00 && cmd_err == 2'b00));

  assert_rdy_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !$fell(rdy[0]) && !$fell(rdy[1]));

  assert_oe_release_R9: assert property (@(posedge clk) disable iff (rst)
    ((!ce0_n || !ce1_n) && we_n && re_n) |=> !bus_oe);

  assert_oe_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_oe) |-> $past(!re_n && !cle && !ale && (!ce0_n || !ce1_n)));

  assert_err0_cause_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_err[0]) |-> $past(!we_n && cle && !ce0_n));

  assert_err1_cause_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_err[1]) |-> $past(!we_n && cle && ce0_n && !ce1_n));

  assert_no_select_R2: assert property (@(posedge clk) disable iff (rst)
    (ce0_n && ce1_n) |=> $stable(cmd_err));
endmodule

bind nandrd_target nandrd_target_chk u_chk (.*);

// File: tb/nandrd_target_bench.sv
module nandrd_target_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce0_n = 1'b1, ce1_n = 1'b1, cle = 1'b0, ale = 1'b0;
  logic we_n = 1'b1, re_n = 1'b1;
  logic [7:0] bus_in = 8'h00;
  logic [7:0] bus_out, bus_out_e;
  logic bus_oe, bus_oe_e;
  logic [1:0] rdy, rdy_e, cmd_err, cmd_err_e;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  int unsigned mptr [2];
  int unsigned moff [2];
  int unsigned macnt [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  nandrd_target #(.ADDR_W(ADDR_W), .FILL_PATTERN(1'b1)) u_nandrd_target (
    .clk(clk), .rst(rst), .ce0_n(ce0_n), .ce1_n(ce1_n), .cle(cle), .ale(ale),
    .we_n(we_n), .re_n(re_n), .bus_in(bus_in), .bus_out(bus_out),
    .bus_oe(bus_oe), .rdy(rdy), .cmd_err(cmd_err));

  nandrd_target #(.ADDR_W(ADDR_W)) u_nandrd_target_erased (
    .clk(clk), .rst(rst), .ce0_n(ce0_n), .ce1_n(ce1_n), .cle(cle), .ale(ale),
    .we_n(we_n), .re_n(re_n), .bus_in(bus_in), .bus_out(bus_out_e),
    .bus_oe(bus_oe_e), .rdy(rdy_e), .cmd_err(cmd_err_e));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int unsigned wrapp(input longint unsigned v);
    return int'(v % (64'd1 << ADDR_W));
  endfunction

  function automatic logic [7:0] exp_byte(input int dev, input int unsigned p);
    logic [31:0] a;
    a = p;
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ ((dev == 0) ? 8'h00 : 8'hA5);
  endfunction

  task automatic select(input int dev);
    ce0_n = (dev != 0);
    ce1_n = (dev != 1);
  endtask

  task automatic put_byte(input int dev, input bit is_cmd, input logic [7:0] b);
    @(negedge clk);
    select(dev);
    cle = is_cmd; ale = !is_cmd; bus_in = b; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    cle = 1'b0; ale = 1'b0;
    @(negedge clk);
  endtask

  task automatic model_cmd(input int dev, input logic [7:0] b);
    case (b)
      8'h00: begin moff[dev] = 0; macnt[dev] = 0; end
      8'h01: begin moff[dev] = 'h100; macnt[dev] = 0; end
      8'h50: begin moff[dev] = 'h200; macnt[dev] = 0; end
      8'hFF: moff[dev] = 0;
      default: ;
    endcase
  endtask

  task automatic model_addr(input int dev, input logic [7:0] b);
    case (macnt[dev])
      0: mptr[dev] = wrapp(longint'(b) + moff[dev]);
      1: mptr[dev] = wrapp(longint'(mptr[dev]) + longint'(b) * 135168);
      2: mptr[dev] = wrapp(longint'(mptr[dev]) + longint'(b) * 528);
      default: ;
    endcase
    if (macnt[dev] < 3) macnt[dev]++;
  endtask

  task automatic cmd(input int dev, input logic [7:0] b);
    put_byte(dev, 1'b1, b);
    model_cmd(dev, b);
  endtask

  task automatic addr3(input int dev, input logic [7:0] c, input logic [7:0] hi, input logic [7:0] lo);
    put_byte(dev, 1'b0, c);  model_addr(dev, c);
    put_byte(dev, 1'b0, hi); model_addr(dev, hi);
    put_byte(dev, 1'b0, lo); model_addr(dev, lo);
  endtask

  task automatic read_check(input int dev, input string req);
    logic [7:0] got;
    logic oe;
    logic [7:0] want;
    @(negedge clk);
    select(dev);
    re_n = 1'b0;
    @(negedge clk);
    got = bus_out; oe = bus_oe;
    want = exp_byte(dev, mptr[dev]);
    check(got == want, req, got, want);
    check(oe == 1'b1, {req, " R7 oe"}, oe, 1);
    mptr[dev] = wrapp(longint'(mptr[dev]) + 1);
    re_n = 1'b1;
    @(negedge clk);
    check(bus_oe == 1'b0, "R9 oe release", bus_oe, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(bus_oe == 1'b0, "R1 bus_oe", bus_oe, 0);
    check(bus_out == 8'h00, "R1 bus_out", bus_out, 0);
    check(rdy == 2'b00, "R1 rdy", rdy, 0);
    check(cmd_err == 2'b00, "R1 cmd_err", cmd_err, 0);
    rst = 1'b0;
  endtask

  task automatic t_mode_a;
    cmd(0, 8'h00);
    check(rdy[0] == 1'b1, "R9 rdy0", rdy[0], 1);
    addr3(0, 8'h10, 8'h00, 8'h02);
    read_check(0, "R4 R5 mode A start");
    read_check(0, "R7 sequential 1");
    read_check(0, "R7 sequential 2");
  endtask

  task automatic t_mode_b_hi;
    cmd(0, 8'h01);
    addr3(0, 8'h22, 8'h01, 8'h00);
    read_check(0, "R3 R5 mode B high weight");
  endtask

  task automatic t_mode_c;
    cmd(0, 8'h50);
    addr3(0, 8'h07, 8'h00, 8'h05);
    read_check(0, "R3 mode C offset");
  endtask

  task automatic t_extra_addr;
    cmd(0, 8'h00);
    addr3(0, 8'h40, 8'h00, 8'h03);
    put_byte(0, 1'b0, 8'h99); model_addr(0, 8'h99);
    read_check(0, "R5 extra address ignored");
  endtask

  task automatic t_wrap;
    cmd(0, 8'h50);
    addr3(0, 8'hF0, 8'hFF, 8'hFF);
    read_check(0, "R6 wrap");
  endtask

  task automatic t_devices;
    int unsigned saved;
    saved = mptr[0];
    cmd(1, 8'h01);
    check(rdy[1] == 1'b1, "R9 rdy1", rdy[1], 1);
    addr3(1, 8'h33, 8'h00, 8'h04);
    read_check(1, "R8 R11 device 1 key");
    check(mptr[0] == saved, "R11 model", int'(mptr[0]), int'(saved));
    read_check(0, "R11 device 0 unchanged");
    @(negedge clk);
    ce0_n = 1'b0; ce1_n = 1'b0; re_n = 1'b0;
    @(negedge clk);
    check(bus_out == exp_byte(0, mptr[0]), "R2 priority device 0", bus_out, exp_byte(0, mptr[0]));
    mptr[0] = wrapp(longint'(mptr[0]) + 1);
    re_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_deselect;
    logic [7:0] held;
    held = bus_out;
    @(negedge clk);
    ce0_n = 1'b1; ce1_n = 1'b1;
    cle = 1'b1; bus_in = 8'h77; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1; cle = 1'b0; ale = 1'b1; bus_in = 8'h12;
    @(negedge clk);
    we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1; ale = 1'b0; re_n = 1'b0;
    @(negedge clk);
    re_n = 1'b1;
    @(negedge clk);
    check(cmd_err == 2'b00, "R2 no select err", cmd_err, 0);
    check(bus_out == held, "R2 no select bus_out", bus_out, held);
    read_check(0, "R2 pointer kept");
  endtask

  task automatic t_errors;
    cmd(0, 8'h01);
    cmd(0, 8'h77);
    check(cmd_err == 2'b01, "R10 err set", cmd_err, 1);
    addr3(0, 8'h05, 8'h00, 8'h03);
    read_check(0, "R10 mode unchanged");
    cmd(0, 8'hFF);
    check(cmd_err == 2'b00, "R3 reset clears err", cmd_err, 0);
  endtask

  task automatic t_erased;
    cmd(0, 8'h00);
    addr3(0, 8'h01, 8'h00, 8'h00);
    read_check(0, "R8 pattern read");
    check(bus_out_e == 8'hFF, "R8 erased fill", bus_out_e, 8'hFF);
  endtask

  initial begin
    for (int d = 0; d < 2; d++) begin mptr[d] = 0; moff[d] = 0; macnt[d] = 0; end
    repeat (3) @(negedge clk);
    t_reset();
    t_mode_a();
    t_mode_b_hi();
    t_mode_c();
    t_extra_addr();
    t_wrap();
    t_devices();
    t_deselect();
    t_errors();
    t_erased();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule